// File: doc/BRIEF.md
# Serial Avionics Word Transmitter Channel

This block takes 32-bit avionics data words from a host and sends them on a two-wire, bipolar, return-to-zero line. The host uses a small synchronous register port to set up a control register, to read a status register, and to push words into a transmit FIFO. A word leaves the FIFO as soon as the serializer is free. The serializer can replace the top bit with an odd-parity bit. It then sends the eight label bits most-significant first, followed by bits 9 through 32 in rising order.

Each bit cell pulses one of the two wires for the first half of the cell and drives both wires low for the second half. Consecutive words are separated by at least four bit times of null. The bit rate is either the fast rate or the slow rate. Each rate is given as a half-cell length in clock cycles, so a 125 MHz clock gives 100 kbit/s and 12.5 kbit/s with the default parameters. An interrupt output stays high while any FIFO flag is set.

Top module: `a429_tx_chan`

Register map (`host_addr`):
- 0 = control, read/write.
- 1 = status. A read returns it. A write with bit 3 set clears the overflow bit.
- 2 = FIFO push, write only.

## Requirements
- R1: With control bit 0 set, bit 32 of the sent word equals 1 when bits 1..31 hold an even number of ones, and 0 otherwise (odd parity). Bits 1..31 are sent unchanged.
- R2: With control bit 0 clear, the sent word equals the pushed word exactly.
- R3: Line order is word bits 8,7,6,5,4,3,2,1, then 9,10,…,32 (bit 1 is the LSB of the 32-bit word).
- R4: A 1 is a pulse on `line_hi` and a 0 is a pulse on `line_lo`. Each pulse lasts half a cell and is followed by half a cell with both wires low. The two wires are never high together.
- R5: Control bit 1 set selects a half cell of HALF_FAST clocks; clear selects HALF_SLOW clocks. The rate and parity setting are latched when a word is taken from the FIFO.
- R6: Between the last pulse of one word and the first pulse of the next, the line stays null for at least 4 bit times.
- R7: Transmission starts by itself when the FIFO holds a word, and words go out in push order.
- R8: Status bit 0 = FIFO empty, bit 1 = FIFO count ≥ control bits 7:4, bit 2 = FIFO full, bit 4 = serializer busy. Bits 7:5 read 0.
- R9: `irq` is high exactly when status bit 0, 1 or 2 is high.
- R10: A push to a full FIFO is dropped and sets status bit 3. This bit stays set until a status write with bit 3 set.
- R11: After reset, control reads 0x00, status reads 0x03, both wires are low and `irq` is high. Control reads back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Write strobe for the addressed register |
| host_addr | input | 2 | Register select: 0 control, 1 status, 2 FIFO push |
| host_wdata | input | 32 | Write data (control uses bits 7:0) |
| host_rdata | output | 32 | Registered read data for the address of the previous cycle |
| line_hi | output | 1 | Line wire pulsed for a 1 bit |
| line_lo | output | 1 | Line wire pulsed for a 0 bit |
| irq | output | 1 | High while any FIFO flag is set |

## Verification
The assertions assume that `host_we`, `host_addr` and `host_wdata` are always known and change only between clock edges. They also assume that the overflow bit is cleared only by a status write with bit 3 set. The stimulus drives every host input at the falling clock edge. It changes the rate and parity settings only when the FIFO is empty and the line has been idle for longer than a gap. Because of this, each measured pulse width and gap can be compared with the rate of the word it belongs to. The line monitor in the bench rebuilds each word from the pulses alone.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_PUSH = 2'd2;

  localparam int ST_EMPTY = 0;
  localparam int ST_LEVEL = 1;
  localparam int ST_FULL  = 2;
  localparam int ST_OVF   = 3;
  localparam int ST_BUSY  = 4;

  localparam int LVL_W  = 4;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic [LVL_W-1:0] level;
    logic [1:0]       spare;
    logic             fast;
    logic             par_en;
  } ctrl_t;
endpackage

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  input  logic [LVL_W-1:0] level,
  output logic [WIDTH-1:0] rdata,
  output logic             empty_o,
  output logic             level_o,
  output logic             full_o,
  output logic             any_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             push_ok, pop_ok;
  logic             nxt_empty, nxt_full, nxt_level;

  assign push_ok = push && !full_o;
  assign pop_ok  = pop && !empty_o;

  always_comb begin
    cnt_nxt = cnt;
    if (push_ok && !pop_ok)      cnt_nxt = cnt + 1'b1;
    else if (!push_ok && pop_ok) cnt_nxt = cnt - 1'b1;
  end

  assign nxt_empty = (cnt_nxt == '0);
  assign nxt_full  = (cnt_nxt == CW'(DEPTH));
  assign nxt_level = (32'(cnt_nxt) >= 32'(level));

  // storage without reset so that a block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
    if (pop_ok)  rdata   <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      level_o <= 1'b1;
      any_o   <= 1'b1;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt     <= cnt_nxt;
      empty_o <= nxt_empty;
      full_o  <= nxt_full;
      level_o <= nxt_level;
      any_o   <= nxt_empty | nxt_full | nxt_level;
    end
  end
endmodule

// File: rtl/a429_tx_serial.sv
module a429_tx_serial #(
  parameter int HALF_FAST = 625,
  parameter int HALF_SLOW = 5000,
  parameter int GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        avail,
  input  logic [31:0] word_in,
  input  logic        par_en,
  input  logic        fast,
  output logic        pop,
  output logic        line_hi,
  output logic        line_lo,
  output logic        busy
);
  localparam int MAXH = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int TW   = $clog2(2 * GAP_BITS * MAXH + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_ON, S_OFF, S_GAP} st_t;

  st_t           state;
  logic [TW-1:0] timer, half_len, gap_len;
  logic [4:0]    bits_left;
  logic [31:0]   sreg, word_par, ord;
  logic          rate_q, par_q;

  assign half_len = rate_q ? TW'(HALF_FAST) : TW'(HALF_SLOW);
  assign gap_len  = rate_q ? TW'(2 * GAP_BITS * HALF_FAST) : TW'(2 * GAP_BITS * HALF_SLOW);

  assign word_par = par_q ? {~^word_in[30:0], word_in[30:0]} : word_in;

  // line order: label byte reversed, remaining bits ascending
  for (genvar k = 0; k < 32; k++) begin : g_order
    if (k < 8) begin : g_label
      assign ord[k] = word_par[7-k];
    end else begin : g_body
      assign ord[k] = word_par[k];
    end
  end

  assign pop  = (state == S_IDLE) && avail;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      timer     <= '0;
      bits_left <= '0;
      sreg      <= '0;
      rate_q    <= 1'b0;
      par_q     <= 1'b0;
      line_hi   <= 1'b0;
      line_lo   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (avail) begin
            rate_q <= fast;
            par_q  <= par_en;
            state  <= S_LOAD;
          end
        end
        S_LOAD: begin
          sreg      <= ord;
          line_hi   <= ord[0];
          line_lo   <= !ord[0];
          timer     <= half_len - 1'b1;
          bits_left <= 5'd31;
          state     <= S_ON;
        end
        S_ON: begin
          if (timer == '0) begin
            line_hi <= 1'b0;
            line_lo <= 1'b0;
            timer   <= half_len - 1'b1;
            state   <= S_OFF;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_OFF: begin
          if (timer == '0) begin
            if (bits_left == '0) begin
              timer <= gap_len - 1'b1;
              state <= S_GAP;
            end else begin
              sreg      <= sreg >> 1;
              line_hi   <= sreg[1];
              line_lo   <= !sreg[1];
              bits_left <= bits_left - 1'b1;
              timer     <= half_len - 1'b1;
              state     <= S_ON;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_GAP: begin
          if (timer == '0) state <= S_IDLE;
          else             timer <= timer - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/a429_tx_chan.sv
module a429_tx_chan
  import a429_tx_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HALF_FAST = 625,
  parameter int HALF_SLOW = 5000,
  parameter int GAP_BITS  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        line_hi,
  output logic        line_lo,
  output logic        irq
);
  ctrl_t        ctrl_q;
  logic         ovf_q;
  logic         push, pop, busy;
  logic         fifo_empty, fifo_level, fifo_full;
  logic [31:0]  fifo_rdata;
  logic [7:0]   status;

  assign push = host_we && (host_addr == ADDR_PUSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (host_we && host_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(host_wdata[7:0]);
      if (push && fifo_full)                   ovf_q <= 1'b1;
      else if (host_we && host_addr == ADDR_STAT && host_wdata[ST_OVF]) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_EMPTY] = fifo_empty;
    status[ST_LEVEL] = fifo_level;
    status[ST_FULL]  = fifo_full;
    status[ST_OVF]   = ovf_q;
    status[ST_BUSY]  = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_addr)
        ADDR_CTRL: host_rdata <= {24'd0, ctrl_q};
        ADDR_STAT: host_rdata <= {24'd0, status};
        default:   host_rdata <= '0;
      endcase
    end
  end

  a429_tx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .wdata   (host_wdata),
    .pop     (pop),
    .level   (ctrl_q.level),
    .rdata   (fifo_rdata),
    .empty_o (fifo_empty),
    .level_o (fifo_level),
    .full_o  (fifo_full),
    .any_o   (irq)
  );

  a429_tx_serial #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW), .GAP_BITS(GAP_BITS)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .avail   (!fifo_empty),
    .word_in (fifo_rdata),
    .par_en  (ctrl_q.par_en),
    .fast    (ctrl_q.fast),
    .pop     (pop),
    .line_hi (line_hi),
    .line_lo (line_lo),
    .busy    (busy)
  );
endmodule

module a429_tx_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_we,
  input logic [1:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic        line_hi,
  input logic        line_lo,
  input logic        irq,
  input logic        st_empty,
  input logic        st_full,
  input logic        st_ovf
);
  p_wires_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(line_hi && line_lo));

  p_null_before_one_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_hi) |-> $past(!line_lo));

  p_null_before_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(line_lo) |-> $past(!line_hi));

  p_flags_disjoint_r8: assert property (@(posedge clk) disable iff (rst)
    !(st_empty && st_full));

  p_empty_raises_irq_r9: assert property (@(posedge clk) disable iff (rst)
    st_empty |-> irq);

  p_full_raises_irq_r9: assert property (@(posedge clk) disable iff (rst)
    st_full |-> irq);

  p_overflow_set_r10: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_addr == 2'd2 && st_full) |=> st_ovf);

  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (st_ovf && !(host_we && host_addr == 2'd1 && host_wdata[3])) |=> st_ovf);
endmodule

bind a429_tx_chan a429_tx_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .line_hi    (line_hi),
  .line_lo    (line_lo),
  .irq        (irq),
  .st_empty   (fifo_empty),
  .st_full    (fifo_full),
  .st_ovf     (ovf_q)
);

// File: tb/test_a429_tx_chan.sv
module test_a429_tx_chan;
  localparam int HF    = 3;
  localparam int HS    = 12;
  localparam int DEPTH = 4;
  localparam int GAPB  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        line_hi, line_lo, irq;

  always #4 clk = ~clk;

  a429_tx_chan #(.DEPTH(DEPTH), .HALF_FAST(HF), .HALF_SLOW(HS), .GAP_BITS(GAPB)) i_a429_tx_chan (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .line_hi(line_hi), .line_lo(line_lo), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input logic par);
    int ones = 0;
    for (int i = 0; i < 31; i++) ones += int'(w[i]);
    if (!par) return w;
    return {((ones % 2) == 0) ? 1'b1 : 1'b0, w[30:0]};
  endfunction

  // ---------------- line monitor ----------------
  int          exp_half = HS;
  int          run_on = 0, run_null = 0, bitcnt = 0;
  logic [31:0] bits;
  logic [31:0] rx_words [64];
  int          rx_n = 0;
  bit          have_prev = 0;
  logic        prev_act = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_act = 1'b0; run_on = 0; run_null = 0; bitcnt = 0; have_prev = 0;
    end else begin
      if (line_hi || line_lo) begin
        if (!prev_act) begin
          if (bitcnt == 0 && have_prev) begin
            n_cmp++;
            if (run_null < 2 * GAPB * exp_half) begin
              n_bad++;
              $display("FAIL R6 gap: actual %0d expected >= %0d", run_null, 2 * GAPB * exp_half);
            end
          end
          if (bitcnt > 0) chk("R4 null half", 32'(run_null), 32'(exp_half));
          bits[bitcnt] = line_hi;
          bitcnt++;
          run_on = 0;
        end
        run_on++;
        run_null = 0;
        prev_act = 1'b1;
      end else begin
        if (prev_act) begin
          chk("R4/R5 pulse width", 32'(run_on), 32'(exp_half));
          if (bitcnt == 32) begin
            logic [31:0] w;
            for (int k = 0; k < 32; k++) w[(k < 8) ? 7 - k : k] = bits[k];
            if (rx_n < 64) rx_words[rx_n] = w;
            rx_n++;
            bitcnt = 0;
            have_prev = 1;
          end
        end
        run_null++;
        prev_act = 1'b0;
      end
    end
  end

  // ---------------- host tasks ----------------
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic wait_rx(input int target);
    for (int i = 0; i < 20000 && rx_n < target; i++) @(negedge clk);
  endtask

  // fast, parity enable, word
  localparam logic [33:0] VEC [0:7] = '{
    {1'b0, 1'b0, 32'h8000_0001},
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b1, 1'b1, 32'h0000_0000},
    {1'b1, 1'b1, 32'h7FFF_FFFF},
    {1'b0, 1'b1, 32'hFFFF_FFFF},
    {1'b1, 1'b1, 32'h0000_0003},
    {1'b0, 1'b0, 32'hC3A5_0F81},
    {1'b1, 1'b0, 32'h0000_0080}
  };

  initial begin
    logic [31:0] d;
    int base;
    logic [31:0] burst [6];

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    rd(2'd0, d); chk("R11 ctrl after reset", d, 32'h0);
    rd(2'd1, d); chk("R11 status after reset", d, 32'h03);
    chk("R11 line null after reset", {30'd0, line_hi, line_lo}, 32'h0);
    chk("R11 irq after reset", {31'd0, irq}, 32'h1);

    // R11 control readback
    wr(2'd0, 32'h0000_00F3);
    rd(2'd0, d); chk("R11 ctrl readback", d, 32'hF3);

    // vector table: R1 R2 R3 R5 R7
    for (int v = 0; v < 8; v++) begin
      logic fast, par;
      logic [31:0] w;
      {fast, par, w} = VEC[v];
      exp_half = fast ? HF : HS;
      base = rx_n;
      wr(2'd0, {30'd0, fast, par});
      wr(2'd2, w);
      wait_rx(base + 1);
      chk(par ? "R1/R3 parity word" : "R2/R3 plain word", rx_words[base], expect_word(w, par));
      repeat (300) @(negedge clk);
    end

    // burst: R6 R7 R8 R9 R10
    exp_half = HF;
    wr(2'd0, 32'h0000_0022);
    base = rx_n;
    for (int i = 0; i < 6; i++) burst[i] = 32'hA000_0010 + 32'(i * 32'h0101_0101);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      host_we = 1'b1; host_addr = 2'd2; host_wdata = burst[i];
    end
    @(negedge clk);
    host_we = 1'b0;
    rd(2'd1, d); chk("R8/R10 status full+ovf", d, 32'h1E);
    chk("R9 irq when full", {31'd0, irq}, 32'h1);
    wait_rx(base + 5);
    repeat (600) @(negedge clk);
    chk("R10 dropped word not sent", 32'(rx_n - base), 32'd5);
    for (int i = 0; i < 5; i++) chk("R7 push order", rx_words[base + i], burst[i]);
    rd(2'd1, d); chk("R10 overflow sticky after drain", d, 32'h09);
    wr(2'd1, 32'h0000_0008);
    rd(2'd1, d); chk("R10 overflow cleared", d, 32'h01);

    // level flag: R8 R9
    wr(2'd0, 32'h0000_0032);
    base = rx_n;
    for (int i = 0; i < 4; i++) wr(2'd2, 32'h0F00_0000 + 32'(i));
    rd(2'd1, d); chk("R8 level reached", d, 32'h12);
    chk("R9 irq from level", {31'd0, irq}, 32'h1);
    wait_rx(base + 1);
    repeat (60) @(negedge clk);
    rd(2'd1, d); chk("R8 below level", d, 32'h10);
    chk("R9 irq low with no flag", {31'd0, irq}, 32'h0);
    wait_rx(base + 4);
    for (int i = 0; i < 4; i++) chk("R7 level words order", rx_words[base + i], 32'h0F00_0000 + 32'(i));
    repeat (100) @(negedge clk);
    rd(2'd1, d); chk("R8 drained idle", d, 32'h01);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule